// File: doc/BRIEF.md
# LED Controller Register Target

This block is the register side of a two-wire serial bus target for a four-channel LED controller. A byte-level front end does the bit timing. It hands this block one-cycle event pulses: bus start, bus stop, a received address byte, a received data byte, and a request for a byte to transmit. The block returns an acknowledge decision for every address and data byte. It returns a data byte for every transmit request.

Inside, the block holds the register file and a register pointer. The register file has two mode registers, four channel brightness registers, a group duty and a group period register, an output-state register, three sub-call addresses and an all-call address. The first data byte of a write is a control byte. Its low nibble loads the pointer, and its top three bits choose how the pointer moves after each access. The block also answers the general-call address. When the general call is followed by a fixed two-byte pattern, it restores every register to its power-on value and puts the LED outputs into high impedance.

Top module: `led_reg_if`

## Requirements
- R1: An address byte whose upper seven bits equal the `DEV_ADDR` parameter (default 7'h62) is acknowledged in either direction; bit 0 of an address byte is 1 for a read. An address byte that matches nothing is not acknowledged.
- R2: A control byte with index (bits 3:0) from 0 to 12 is acknowledged. Index 13, 14 or 15 is refused. Every further data byte of that transfer is then refused, and no register changes.
- R3: When bit 7 of the control byte is 0, the pointer never moves, so repeated writes or reads all use the same register.
- R4: Policy codes in control bits 7:5 are as follows. Code 100 steps the pointer through 0..12 and wraps to 0. Code 101 cycles over 2..5. Code 110 cycles over 6..7. Code 111 cycles over 2..7.
- R5: Register 0 reads back the current policy code in bits 7:5, and writes to those bits are ignored. Bit 4 is a sleep flag that drives `led_sleep`.
- R6: Each transmit request returns the register at the pointer and then moves the pointer by the same policy as a write. A repeated start keeps the pointer.
- R7: The register map is: index 1 mode 2, indices 2..5 channel brightness 0..3, 6 group duty, 7 group period, 8 output state, 9..11 sub-call addresses 1..3, 12 all-call address. Sub-call address n (defaults E2h, E4h, E8h) and the all-call address (default E0h) are matched on their upper seven bits. A match counts only while its enable in register 0 is set: bit 3 for sub 1, bit 2 for sub 2, bit 1 for sub 3, bit 0 for all-call.
- R8: The general-call write address (byte 00h) is acknowledged, and the general-call read (01h) is not. After the general-call write, only A5h is acknowledged as the first data byte.
- R9: A5h followed by 5Ah acknowledges both bytes. It then returns every register to its default, clears the policy code and the pointer, and raises `led_hiz`. A wrong second byte, or a stop or start in between, abandons the sequence with no reset.
- R10: `led_hiz` is high out of reset and after a software reset. It drops on the first write to the output-state register (index 8).
- R11: The reset defaults are register 0 = 11h (sleep set, all-call enabled), register 1 = 01h, group duty = FFh, and 00h for brightness, group period and output state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_addr | input | 1 | `bus_byte` holds an address byte |
| ev_wr | input | 1 | `bus_byte` holds a received data byte |
| ev_rd | input | 1 | Front end needs a byte to transmit |
| bus_byte | input | 8 | Received byte |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle after event) |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_vld | output | 1 | `rd_data` valid (one cycle after `ev_rd`) |
| rd_data | output | 8 | Byte to transmit |
| led_sleep | output | 1 | Sleep flag |
| led_hiz | output | 1 | LED outputs high impedance |
| cfg_mode2 | output | 8 | Mode register 2 |
| bright_flat | output | 32 | Channel brightness, channel n at bits 8n+7:8n |
| grp_duty | output | 8 | Group duty |
| grp_period | output | 8 | Group period |
| out_state | output | 8 | Output-state register |

## Verification
The hardest case to reach is the software reset that must not happen. The general call has to land in the second-byte state before a wrong byte, a stop, or an out-of-order byte is sent. The stimulus first changes several registers away from their defaults. It then runs each broken sequence and confirms through the outputs that those values survive. Only after that does it send the complete A5h/5Ah pattern and check that every output returns to its default. The pointer policies are reached by writing runs long enough to cross each wrap point, and by reading the pointer back across a repeated start.

// File: rtl/ledreg_pkg.sv
package ledreg_pkg;
  localparam int NREG  = 13;
  localparam int IDX_W = 4;
  localparam int NCH   = 4;

  localparam logic [IDX_W-1:0] IX_MODE1 = 4'd0;
  localparam logic [IDX_W-1:0] IX_MODE2 = 4'd1;
  localparam logic [IDX_W-1:0] IX_BR0   = 4'd2;
  localparam logic [IDX_W-1:0] IX_BR3   = 4'd5;
  localparam logic [IDX_W-1:0] IX_GDUTY = 4'd6;
  localparam logic [IDX_W-1:0] IX_GPER  = 4'd7;
  localparam logic [IDX_W-1:0] IX_OUT   = 4'd8;
  localparam logic [IDX_W-1:0] IX_SUB1  = 4'd9;
  localparam logic [IDX_W-1:0] IX_SUB2  = 4'd10;
  localparam logic [IDX_W-1:0] IX_SUB3  = 4'd11;
  localparam logic [IDX_W-1:0] IX_ALL   = 4'd12;
  localparam logic [IDX_W-1:0] IX_LAST  = IX_ALL;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  typedef logic [NREG-1:0][7:0] regs_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_DATA, ST_READ, ST_GC1, ST_GC2
  } xfer_t;

  // Power-on value of each register index.
  function automatic logic [7:0] reg_default(input logic [IDX_W-1:0] i);
    case (i)
      IX_MODE1: return 8'h11;
      IX_MODE2: return 8'h01;
      IX_GDUTY: return 8'hFF;
      IX_SUB1:  return 8'hE2;
      IX_SUB2:  return 8'hE4;
      IX_SUB3:  return 8'hE8;
      IX_ALL:   return 8'hE0;
      default:  return 8'h00;
    endcase
  endfunction

  // Pointer step for a policy code; bit 2 clear means the pointer stays.
  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] p,
                                                 input logic [2:0] pol);
    logic [IDX_W-1:0] lo, hi;
    case (pol)
      3'b101:  begin lo = IX_BR0;   hi = IX_BR3;  end
      3'b110:  begin lo = IX_GDUTY; hi = IX_GPER; end
      3'b111:  begin lo = IX_BR0;   hi = IX_GPER; end
      default: begin lo = IX_MODE1; hi = IX_LAST; end
    endcase
    if (!pol[2])        return p;
    else if (p == hi)   return lo;
    else if (p >= IX_LAST) return IX_MODE1;
    else                return p + 4'd1;
  endfunction
endpackage

// File: rtl/led_addr_match.sv
module led_addr_match
  import ledreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h62
) (
  input  logic [6:0] addr7,
  input  logic [7:0] mode1,
  input  logic [7:0] sub1,
  input  logic [7:0] sub2,
  input  logic [7:0] sub3,
  input  logic [7:0] allc,
  output logic       hit,
  output logic       gcall
);
  logic own_hit, s1_hit, s2_hit, s3_hit, all_hit;

  always_comb begin
    own_hit = (addr7 == DEV_ADDR);
    s1_hit  = mode1[3] && (addr7 == sub1[7:1]);
    s2_hit  = mode1[2] && (addr7 == sub2[7:1]);
    s3_hit  = mode1[1] && (addr7 == sub3[7:1]);
    all_hit = mode1[0] && (addr7 == allc[7:1]);
    hit     = own_hit | s1_hit | s2_hit | s3_hit | all_hit;
    gcall   = (addr7 == 7'd0);
  end
endmodule

// File: rtl/led_regfile.sv
module led_regfile
  import ledreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swrst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output regs_t            regs,
  output logic             hiz
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(IDX_W'(i));
      hiz <= 1'b1;
    end else if (swrst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_default(IDX_W'(i));
      hiz <= 1'b1;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_idx == IDX_W'(i))
          regs[i] <= (i == 0) ? {3'b000, wr_data[4:0]} : wr_data;
      end
      if (wr_idx == IX_OUT) hiz <= 1'b0;
    end
  end

  AST_HIZ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swrst && wr_idx == IX_OUT) |=> !hiz); // R10
  AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0][7:5] == 3'b000); // R5
endmodule

// File: rtl/led_reg_if.sv
module led_reg_if
  import ledreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h62
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        ev_addr,
  input  logic        ev_wr,
  input  logic        ev_rd,
  input  logic [7:0]  bus_byte,
  output logic        ack_vld,
  output logic        ack,
  output logic        rd_vld,
  output logic [7:0]  rd_data,
  output logic        led_sleep,
  output logic        led_hiz,
  output logic [7:0]  cfg_mode2,
  output logic [31:0] bright_flat,
  output logic [7:0]  grp_duty,
  output logic [7:0]  grp_period,
  output logic [7:0]  out_state
);
  xfer_t            st;
  logic [IDX_W-1:0] ptr;
  logic [2:0]       pol;
  regs_t            regs;
  logic             hit, gcall;

  // Named internal events
  logic             ctrl_ev, ctrl_ok, wr_hit, swrst_fire, rd_hit;
  logic [7:0]       rd_mux;

  assign ctrl_ev    = ev_wr && (st == ST_CTRL);
  assign ctrl_ok    = ctrl_ev && (bus_byte[3:0] <= IX_LAST);
  assign wr_hit     = ev_wr && (st == ST_DATA) && !ev_start && !ev_stop && !ev_addr;
  assign swrst_fire = ev_wr && (st == ST_GC2) && (bus_byte == KEY_SECOND)
                      && !ev_start && !ev_stop && !ev_addr;
  assign rd_hit     = ev_rd && (st == ST_READ);
  assign rd_mux     = (ptr == IX_MODE1) ? {pol, regs[0][4:0]} : regs[ptr];

  led_addr_match #(.DEV_ADDR(DEV_ADDR)) u_match (
    .addr7 (bus_byte[7:1]),
    .mode1 (regs[IX_MODE1]),
    .sub1  (regs[IX_SUB1]),
    .sub2  (regs[IX_SUB2]),
    .sub3  (regs[IX_SUB3]),
    .allc  (regs[IX_ALL]),
    .hit   (hit),
    .gcall (gcall)
  );

  led_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .swrst   (swrst_fire),
    .wr_en   (wr_hit),
    .wr_idx  (ptr),
    .wr_data (bus_byte),
    .regs    (regs),
    .hiz     (led_hiz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr     <= IX_MODE1;
      pol     <= 3'b000;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      rd_vld  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      ack_vld <= 1'b0;
      rd_vld  <= 1'b0;
      if (ev_start || ev_stop) begin
        st <= ST_IDLE;
      end else if (ev_addr) begin
        ack_vld <= 1'b1;
        if (hit) begin
          ack <= 1'b1;
          st  <= bus_byte[0] ? ST_READ : ST_CTRL;
        end else if (gcall && !bus_byte[0]) begin
          ack <= 1'b1;
          st  <= ST_GC1;
        end else begin
          ack <= 1'b0;
          st  <= ST_IDLE;
        end
      end else if (ev_wr) begin
        ack_vld <= 1'b1;
        case (st)
          ST_CTRL: begin
            ack <= ctrl_ok;
            st  <= ctrl_ok ? ST_DATA : ST_IDLE;
            if (ctrl_ok) begin
              ptr <= bus_byte[3:0];
              pol <= bus_byte[7:5];
            end
          end
          ST_DATA: begin
            ack <= 1'b1;
            ptr <= next_ptr(ptr, pol);
          end
          ST_GC1: begin
            ack <= (bus_byte == KEY_FIRST);
            st  <= (bus_byte == KEY_FIRST) ? ST_GC2 : ST_IDLE;
          end
          ST_GC2: begin
            ack <= swrst_fire;
            st  <= ST_IDLE;
            if (swrst_fire) begin
              ptr <= IX_MODE1;
              pol <= 3'b000;
            end
          end
          default: ack <= 1'b0;
        endcase
      end else if (rd_hit) begin
        rd_vld  <= 1'b1;
        rd_data <= rd_mux;
        ptr     <= next_ptr(ptr, pol);
      end
    end
  end

  assign led_sleep  = regs[IX_MODE1][4];
  assign cfg_mode2  = regs[IX_MODE2];
  assign grp_duty   = regs[IX_GDUTY];
  assign grp_period = regs[IX_GPER];
  assign out_state  = regs[IX_OUT];

  for (genvar c = 0; c < NCH; c++) begin : g_bright
    assign bright_flat[c*8 +: 8] = regs[IX_BR0 + IDX_W'(c)];
  end

  AST_RSVD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_ev && !ev_start && !ev_stop && !ev_addr && bus_byte[3:0] > IX_LAST)
      |=> (ack_vld && !ack)); // R2
  AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_hit || rd_hit) && !pol[2]) |=> $stable(ptr)); // R3
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= IX_LAST); // R4
  AST_GC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && st == ST_GC1 && !ev_start && !ev_stop && !ev_addr && bus_byte != KEY_FIRST)
      |=> (ack_vld && !ack)); // R8
  AST_SWRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_fire |=> (led_hiz && led_sleep && grp_duty == 8'hFF)); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_vld && rd_vld)); // R6
endmodule

// File: tb/led_reg_if_bench.sv
module led_reg_if_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_start = 1'b0, ev_stop = 1'b0, ev_addr = 1'b0, ev_wr = 1'b0, ev_rd = 1'b0;
  logic [7:0]  bus_byte = 8'h00;
  logic        ack_vld, ack, rd_vld;
  logic [7:0]  rd_data, cfg_mode2, grp_duty, grp_period, out_state;
  logic        led_sleep, led_hiz;
  logic [31:0] bright_flat;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    bit         is_rd;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  led_reg_if u_led_reg_if (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr(ev_addr), .ev_wr(ev_wr), .ev_rd(ev_rd), .bus_byte(bus_byte),
    .ack_vld(ack_vld), .ack(ack), .rd_vld(rd_vld), .rd_data(rd_data),
    .led_sleep(led_sleep), .led_hiz(led_hiz), .cfg_mode2(cfg_mode2),
    .bright_flat(bright_flat), .grp_duty(grp_duty), .grp_period(grp_period),
    .out_state(out_state)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Monitor: pops one expected item per result the design produces.
  always @(negedge clk) begin
    if (rst_n && (ack_vld || rd_vld)) begin
      if (q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL unexpected result: actual ack_vld=%0b rd_vld=%0b expected none", ack_vld, rd_vld);
      end else begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (e.is_rd != rd_vld) begin
          n_fail++;
          $display("FAIL %s: actual kind rd=%0b expected rd=%0b", e.tag, rd_vld, e.is_rd);
        end else if (rd_vld && rd_data !== e.val) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", e.tag, rd_data, e.val);
        end else if (ack_vld && ack !== e.val[0]) begin
          n_fail++;
          $display("FAIL %s: actual ack %0b expected %0b", e.tag, ack, e.val[0]);
        end
      end
    end
  end

  task automatic bstart();
    @(negedge clk) ev_start = 1'b1;
    @(negedge clk) ev_start = 1'b0;
  endtask
  task automatic bstop();
    @(negedge clk) ev_stop = 1'b1;
    @(negedge clk) ev_stop = 1'b0;
  endtask
  task automatic send_addr(input logic [7:0] b, input bit exp_ack, input string tag);
    q.push_back('{1'b0, {7'd0, exp_ack}, tag});
    @(negedge clk) begin ev_addr = 1'b1; bus_byte = b; end
    @(negedge clk) ev_addr = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    q.push_back('{1'b0, {7'd0, exp_ack}, tag});
    @(negedge clk) begin ev_wr = 1'b1; bus_byte = b; end
    @(negedge clk) ev_wr = 1'b0;
  endtask
  task automatic read_byte(input logic [7:0] expv, input string tag);
    q.push_back('{1'b1, expv, tag});
    @(negedge clk) ev_rd = 1'b1;
    @(negedge clk) ev_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(led_sleep, 1, "R11 sleep default");
    check(led_hiz, 1, "R10 hiz after reset");
    check(grp_duty, 8'hFF, "R11 duty default");
    check(bright_flat, 0, "R11 brightness default");
    check(cfg_mode2, 8'h01, "R11 mode2 default");

    // R4 policy 100 across full map with wrap to 0
    bstart();
    send_addr(8'hC4, 1, "R1 own address write");
    send_byte(8'h82, 1, "R2 valid control");
    begin
      logic [7:0] vals [12] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                                8'h00, 8'hE2, 8'hE4, 8'hE8, 8'hE0, 8'h01};
      foreach (vals[i]) send_byte(vals[i], 1, "R4 incrementing write");
    end
    bstop();
    check(bright_flat, 32'h44332211, "R4 brightness run");
    check(grp_duty, 8'h55, "R4 duty");
    check(grp_period, 8'h66, "R4 period");
    check(led_hiz, 0, "R10 hiz cleared by output write");
    check(led_sleep, 0, "R4 wrap to register 0");

    bstart();
    send_addr(8'h66, 0, "R1 foreign address");
    bstop();

    // R2 reserved index
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'h8D, 0, "R2 reserved index refused");
    send_byte(8'h77, 0, "R2 data after reserved refused");
    bstop();
    check(grp_duty, 8'h55, "R2 no register change");
    check(bright_flat, 32'h44332211, "R2 brightness unchanged");

    // R3 fixed pointer
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'h06, 1, "R3 control fixed");
    send_byte(8'hAA, 1, "R3 write 1");
    send_byte(8'hBB, 1, "R3 write 2");
    bstop();
    check(grp_duty, 8'hBB, "R3 same register");
    check(grp_period, 8'h66, "R3 neighbour untouched");

    // R4 subset policies
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'hA5, 1, "R4 policy 101");
    send_byte(8'h01, 1, "R4 br3");
    send_byte(8'h02, 1, "R4 wrap br0");
    bstop();
    check(bright_flat, 32'h01332202, "R4 brightness ring");
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'hC7, 1, "R4 policy 110");
    send_byte(8'h09, 1, "R4 period");
    send_byte(8'h0A, 1, "R4 wrap duty");
    bstop();
    check(grp_period, 8'h09, "R4 ring 110 period");
    check(grp_duty, 8'h0A, "R4 ring 110 duty");
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'hE7, 1, "R4 policy 111");
    send_byte(8'h5B, 1, "R4 period");
    send_byte(8'h5C, 1, "R4 wrap br0");
    bstop();
    check(grp_period, 8'h5B, "R4 ring 111 period");
    check(bright_flat[7:0], 8'h5C, "R4 ring 111 wrap");

    // R6 reads across repeated start
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'h80, 1, "R6 set pointer");
    bstart();
    send_addr(8'hC5, 1, "R1 own address read");
    read_byte(8'h81, "R5 policy readback");
    read_byte(8'h01, "R6 mode2 read");
    read_byte(8'h5C, "R6 br0 read");
    bstop();

    // R5 read-only bits
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'h00, 1, "R5 control");
    send_byte(8'hE1, 1, "R5 write top bits");
    bstart();
    send_addr(8'hC5, 1, "R1 own address read");
    read_byte(8'h01, "R5 top bits ignored");
    read_byte(8'h01, "R3 fixed pointer read");
    bstop();

    // R7 sub-call and all-call
    bstart();
    send_addr(8'hE2, 0, "R7 sub1 disabled");
    bstop();
    bstart();
    send_addr(8'hC4, 1, "R1 own address");
    send_byte(8'h00, 1, "R7 control");
    send_byte(8'h19, 1, "R7 enable sub1");
    bstop();
    check(led_sleep, 1, "R5 sleep set");
    bstart();
    send_addr(8'hE2, 1, "R7 sub1 enabled");
    bstop();
    bstart();
    send_addr(8'hE4, 0, "R7 sub2 disabled");
    bstop();
    bstart();
    send_addr(8'hE1, 1, "R7 all-call read");
    read_byte(8'h19, "R7 read via all-call");
    bstop();

    // R8 general call
    bstart();
    send_addr(8'h00, 1, "R8 general call write");
    send_byte(8'h11, 0, "R8 wrong first byte");
    bstop();
    bstart();
    send_addr(8'h01, 0, "R8 general call read");
    bstop();

    // R9 abandoned sequences
    bstart();
    send_addr(8'h00, 1, "R8 general call");
    send_byte(8'hA5, 1, "R8 first key");
    bstop();
    bstart();
    send_addr(8'h00, 1, "R8 general call");
    send_byte(8'h5A, 0, "R9 second key alone refused");
    bstop();
    check(grp_duty, 8'h0A, "R9 no reset after stop");
    bstart();
    send_addr(8'h00, 1, "R8 general call");
    send_byte(8'hA5, 1, "R8 first key");
    send_byte(8'h3C, 0, "R9 wrong second key");
    bstop();
    check(grp_duty, 8'h0A, "R9 no reset after wrong key");
    check(led_hiz, 0, "R9 hiz unchanged");

    // R9 full reset
    bstart();
    send_addr(8'h00, 1, "R8 general call");
    send_byte(8'hA5, 1, "R8 first key");
    send_byte(8'h5A, 1, "R9 second key");
    bstop();
    check(grp_duty, 8'hFF, "R9 duty default");
    check(grp_period, 8'h00, "R9 period default");
    check(bright_flat, 0, "R9 brightness default");
    check(led_hiz, 1, "R9 hiz after reset");
    check(led_sleep, 1, "R9 sleep default");
    bstart();
    send_addr(8'hC5, 1, "R1 own address read");
    read_byte(8'h11, "R9 pointer and policy cleared");
    bstop();
    bstart();
    send_addr(8'hE2, 0, "R9 sub1 enable cleared");
    bstop();

    repeat (3) @(negedge clk);
    check(q.size(), 0, "R6 all results produced");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule